// File: doc/BRIEF.md
# Daisy-Chained Interrupt Priority Arbiter

This block arbitrates interrupt requests from a fixed chain of devices in front of a CPU. The chain has 34 positions. Position 0 is the interval timer and sits nearest the CPU. Position 1 is the keyboard controller. Positions 2 to 33 are expansion slots 0 to 31. The CPU acknowledge enters the chain at the timer and travels outward. Each position passes the acknowledge on only when it is not requesting itself. The first requesting position therefore takes the acknowledge, and every position behind it is ignored for that pass.

The block raises the CPU interrupt line whenever any position requests. The CPU responds with an acknowledge pulse. On that clock edge the block registers a one-hot grant for the winning device. It also copies that device's 32-bit interrupt message onto the CPU side, together with a valid flag, for exactly one cycle. A device that lost keeps its request asserted and wins on a later acknowledge, once every position ahead of it has gone quiet.

Top module: `irq_daisy_chain`

## Requirements
- R1: While reset is held low and in the first cycle after it is released, all grant outputs, `cpu_msg_valid` and `cpu_msg` are zero.
- R2: `cpu_int` is high in the same cycle exactly when at least one timer, keyboard or slot request is high.
- R3: If `cpu_ack` is high at a clock edge while `timer_req` is high, only `timer_grant` is set in the following cycle, whatever the other requests are.
- R4: If the timer is not requesting and `kbd_req` is high at an acknowledged edge, only `kbd_grant` is set in the next cycle, even if slots request.
- R5: When only slots request at an acknowledged edge, the lowest-numbered requesting slot gets its bit of `slot_grant` (bit n = slot n) in the next cycle, and no other grant is set.
- R6: At most one grant output bit is high in any cycle. A grant lasts exactly one cycle per acknowledge.
- R7: In the cycle a grant is high, `cpu_msg_valid` is high and `cpu_msg` equals the message input of the granted device. For slot n, that is `slot_msg[32*n +: 32]`.
- R8: An acknowledge given while nothing is requesting produces no grant and leaves `cpu_msg_valid` low.
- R9: A requesting device that loses arbitration is granted on a later acknowledge once no higher-priority device is requesting.
- R10: Without `cpu_ack`, no grant is produced, even if requests are present.
- R11: `cpu_msg` is zero in every cycle in which `cpu_msg_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| timer_req | input | 1 | Interval timer interrupt request (chain position 0) |
| kbd_req | input | 1 | Keyboard controller interrupt request (chain position 1) |
| slot_req | input | 32 | Expansion slot requests, bit n = slot n |
| timer_msg | input | 32 | Interval timer interrupt message |
| kbd_msg | input | 32 | Keyboard controller interrupt message |
| slot_msg | input | 1024 | Slot messages, slot n at bits 32*n+31 : 32*n |
| cpu_ack | input | 1 | CPU interrupt acknowledge; one pulse = one arbitration pass |
| cpu_int | output | 1 | Interrupt line to the CPU |
| timer_grant | output | 1 | Grant to the interval timer |
| kbd_grant | output | 1 | Grant to the keyboard controller |
| slot_grant | output | 32 | One-hot grant to an expansion slot |
| cpu_msg | output | 32 | Message of the granted device |
| cpu_msg_valid | output | 1 | `cpu_msg` holds a granted message |

## Verification
The assertions assume that requests and messages are stable around the acknowledged edge. They also assume `cpu_ack` is a plain level sampled at each edge, and that nothing is known about how long a device keeps its request. The bench meets these assumptions by changing every input only at the falling edge. It holds each request pattern steady across the acknowledge. It lowers the acknowledge before the result is sampled, so every pass covers exactly one edge. Devices that lose are left requesting, and a winner's request is withdrawn only after its grant has been observed. This mirrors how a serviced device clears its own request.

// File: rtl/irq_chain_pkg.sv
// Package: shared constants for the interrupt priority chain.
// Assumes position 0 is nearest the CPU; lower index means higher priority.
package irq_chain_pkg;
    // Fixed chain positions of the integrated devices
    localparam int unsigned POS_TIMER = 0;
    localparam int unsigned POS_KBD   = 1;
    localparam int unsigned POS_SLOT0 = 2;

    // Number of chain positions for a given expansion slot count
    function automatic int unsigned chain_len(input int unsigned n_slots);
        return n_slots + POS_SLOT0;
    endfunction
endpackage

// File: rtl/irq_chain_link.sv
// One stage of the acknowledge chain.
// Takes the acknowledge arriving from the CPU side. It claims the acknowledge
// when its device requests, and otherwise passes it on to the next stage.
// Assumes purely combinational use inside a registered arbiter.
module irq_chain_link (
    input  logic ack_in,
    input  logic req,
    output logic win,
    output logic ack_out
);
    // Claim or forward the acknowledge
    always_comb begin
        win     = ack_in & req;
        ack_out = ack_in & ~req;
    end
endmodule

// File: rtl/irq_msg_mux.sv
// AND-OR multiplexer that selects one message per one-hot select vector.
// Assumes sel has at most one bit set; all-zero select yields zero.
module irq_msg_mux #(
    parameter int unsigned N_POS = 34,
    parameter int unsigned MSG_W = 32
) (
    input  logic [N_POS-1:0]       sel,
    input  logic [N_POS*MSG_W-1:0] msgs,
    output logic [MSG_W-1:0]       msg_out
);
    // Merge the masked message of each position
    always_comb begin
        msg_out = '0;
        for (int p = 0; p < N_POS; p++) begin
            msg_out = msg_out | (msgs[p*MSG_W +: MSG_W] & {MSG_W{sel[p]}});
        end
    end
endmodule

// File: rtl/irq_grant_reg.sv
// Output register stage of the arbiter.
// Captures the winning one-hot vector and the selected message on each edge.
// The valid flag is captured from the chain tail rather than from the grant.
// Assumes synchronous active-low reset.
module irq_grant_reg #(
    parameter int unsigned N_POS = 34,
    parameter int unsigned MSG_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_POS-1:0] win_d,
    input  logic [MSG_W-1:0] msg_d,
    input  logic             valid_d,
    output logic [N_POS-1:0] grant_q,
    output logic [MSG_W-1:0] msg_q,
    output logic             valid_q
);
    // One-cycle grant, message and valid flag per acknowledge
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            grant_q <= '0;
            msg_q   <= '0;
            valid_q <= 1'b0;
        end else begin
            grant_q <= win_d;
            msg_q   <= msg_d;
            valid_q <= valid_d;
        end
    end
endmodule

// File: rtl/irq_daisy_chain.sv
// Daisy-chained interrupt priority arbiter.
// The order is fixed: timer, then keyboard controller, then slots 0..N_SLOTS-1.
// The CPU acknowledge enters at the timer and is claimed by the first
// requesting position. The winner is registered as a one-hot grant, and its
// message is registered toward the CPU for one cycle.
// Assumes requests and messages are stable around the acknowledged edge.
module irq_daisy_chain
    import irq_chain_pkg::*;
#(
    parameter int unsigned N_SLOTS = 32,
    parameter int unsigned MSG_W   = 32
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   timer_req,
    input  logic                   kbd_req,
    input  logic [N_SLOTS-1:0]     slot_req,
    input  logic [MSG_W-1:0]       timer_msg,
    input  logic [MSG_W-1:0]       kbd_msg,
    input  logic [N_SLOTS*MSG_W-1:0] slot_msg,
    input  logic                   cpu_ack,
    output logic                   cpu_int,
    output logic                   timer_grant,
    output logic                   kbd_grant,
    output logic [N_SLOTS-1:0]     slot_grant,
    output logic [MSG_W-1:0]       cpu_msg,
    output logic                   cpu_msg_valid
);
    localparam int unsigned N_POS = chain_len(N_SLOTS);

    logic [N_POS-1:0]       req_vec;
    logic [N_POS*MSG_W-1:0] msg_vec;
    logic [N_POS:0]         ack_chain;
    logic [N_POS-1:0]       win_vec;
    logic [MSG_W-1:0]       sel_msg;
    logic [N_POS-1:0]       grant_vec;

    // Arrange requests and messages in chain order
    always_comb begin
        req_vec = {slot_req, kbd_req, timer_req};
        msg_vec = {slot_msg, kbd_msg, timer_msg};
    end

    // Interrupt line: any position requesting
    always_comb cpu_int = |req_vec;

    // Acknowledge enters at the position nearest the CPU
    always_comb ack_chain[0] = cpu_ack;

    // One link per chain position
    for (genvar p = 0; p < N_POS; p++) begin : g_link
        irq_chain_link u_link (
            .ack_in  (ack_chain[p]),
            .req     (req_vec[p]),
            .win     (win_vec[p]),
            .ack_out (ack_chain[p+1])
        );
    end

    irq_msg_mux #(
        .N_POS (N_POS),
        .MSG_W (MSG_W)
    ) u_mux (
        .sel     (win_vec),
        .msgs    (msg_vec),
        .msg_out (sel_msg)
    );

    // Valid when an acknowledge was claimed before the chain tail
    irq_grant_reg #(
        .N_POS (N_POS),
        .MSG_W (MSG_W)
    ) u_reg (
        .clk     (clk),
        .rst_n   (rst_n),
        .win_d   (win_vec),
        .msg_d   (sel_msg),
        .valid_d (cpu_ack & ~ack_chain[N_POS]),
        .grant_q (grant_vec),
        .msg_q   (cpu_msg),
        .valid_q (cpu_msg_valid)
    );

    // Split the registered grant back into device groups
    always_comb begin
        timer_grant = grant_vec[POS_TIMER];
        kbd_grant   = grant_vec[POS_KBD];
        slot_grant  = grant_vec[N_POS-1:POS_SLOT0];
    end
endmodule

// File: rtl/irq_daisy_chain_chk.sv
// Checker for the interrupt priority arbiter, bound into the top module.
// Assumes synchronous active-low reset and inputs sampled at the rising edge.
module irq_daisy_chain_chk #(
    parameter int unsigned N_POS = 34,
    parameter int unsigned MSG_W = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cpu_ack,
    input logic [N_POS-1:0] req_vec,
    input logic [N_POS-1:0] grant_vec,
    input logic [MSG_W-1:0] cpu_msg,
    input logic             cpu_msg_valid
);
    // R6
    grant_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant_vec));

    // R3
    timer_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_ack && req_vec[0]) |=> grant_vec[0]);

    // R8
    empty_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_ack && req_vec == '0) |=> (grant_vec == '0 && !cpu_msg_valid));

    // R10
    no_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cpu_ack |=> (grant_vec == '0));

    // R7
    valid_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_msg_valid == (grant_vec != '0));

    // R11
    idle_msg_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cpu_msg_valid |-> (cpu_msg == '0));
endmodule

bind irq_daisy_chain irq_daisy_chain_chk #(
    .N_POS (N_POS),
    .MSG_W (MSG_W)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .cpu_ack       (cpu_ack),
    .req_vec       (req_vec),
    .grant_vec     (grant_vec),
    .cpu_msg       (cpu_msg),
    .cpu_msg_valid (cpu_msg_valid)
);

// File: tb/test_irq_daisy_chain.sv
module test_irq_daisy_chain;
    localparam int CLK_PERIOD = 10;
    localparam int NS = 32;
    localparam int MW = 32;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            timer_req = 1'b0;
    logic            kbd_req = 1'b0;
    logic [NS-1:0]   slot_req = '0;
    logic [MW-1:0]   timer_msg;
    logic [MW-1:0]   kbd_msg;
    logic [NS*MW-1:0] slot_msg;
    logic            cpu_ack = 1'b0;
    logic            cpu_int;
    logic            timer_grant;
    logic            kbd_grant;
    logic [NS-1:0]   slot_grant;
    logic [MW-1:0]   cpu_msg;
    logic            cpu_msg_valid;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    irq_daisy_chain i_irq_daisy_chain (
        .clk(clk), .rst_n(rst_n),
        .timer_req(timer_req), .kbd_req(kbd_req), .slot_req(slot_req),
        .timer_msg(timer_msg), .kbd_msg(kbd_msg), .slot_msg(slot_msg),
        .cpu_ack(cpu_ack), .cpu_int(cpu_int),
        .timer_grant(timer_grant), .kbd_grant(kbd_grant), .slot_grant(slot_grant),
        .cpu_msg(cpu_msg), .cpu_msg_valid(cpu_msg_valid)
    );

    // Distinct message per device
    function automatic logic [MW-1:0] slot_code(input int n);
        return 32'h5100_0000 | (n * 32'h0001_0101);
    endfunction

    initial begin
        timer_msg = 32'hA1A1_0001;
        kbd_msg   = 32'hB2B2_0002;
        for (int n = 0; n < NS; n++) slot_msg[n*MW +: MW] = slot_code(n);
    end

    task automatic check_out(input string tag, input logic et, input logic ek,
                             input logic [NS-1:0] es, input logic [MW-1:0] em,
                             input logic ev);
        checks++;
        if (timer_grant !== et || kbd_grant !== ek || slot_grant !== es ||
            cpu_msg !== em || cpu_msg_valid !== ev) begin
            errors++;
            $display("FAIL %s: got t=%b k=%b s=%h msg=%h v=%b, expected t=%b k=%b s=%h msg=%h v=%b",
                     tag, timer_grant, kbd_grant, slot_grant, cpu_msg, cpu_msg_valid,
                     et, ek, es, em, ev);
        end
    endtask

    task automatic check_int(input string tag, input logic e);
        checks++;
        if (cpu_int !== e) begin
            errors++;
            $display("FAIL %s: cpu_int=%b expected %b", tag, cpu_int, e);
        end
    endtask

    // One acknowledged edge, then sample at the next falling edge
    task automatic ack_pass();
        cpu_ack = 1'b1;
        @(negedge clk);
        cpu_ack = 1'b0;
    endtask

    task automatic clear_reqs();
        timer_req = 1'b0; kbd_req = 1'b0; slot_req = '0;
    endtask

    task automatic t_reset();
        timer_req = 1'b1; slot_req = 32'hFFFF_FFFF; cpu_ack = 1'b1;
        repeat (2) @(negedge clk);
        check_out("R1 in reset", 0, 0, '0, '0, 0);
        cpu_ack = 1'b0; clear_reqs();
        rst_n = 1'b1;
        @(negedge clk);
        check_out("R1 after release", 0, 0, '0, '0, 0);
    endtask

    task automatic t_int_line();
        check_int("R2 idle", 1'b0);
        slot_req[7] = 1'b1; #1;
        check_int("R2 slot7", 1'b1);
        slot_req = '0; kbd_req = 1'b1; #1;
        check_int("R2 kbd", 1'b1);
        kbd_req = 1'b0; #1;
        check_int("R2 released", 1'b0);
        @(negedge clk);
    endtask

    task automatic t_no_ack();
        timer_req = 1'b1; slot_req[3] = 1'b1;
        repeat (3) @(negedge clk);
        check_out("R10 no ack", 0, 0, '0, '0, 0);
        clear_reqs(); @(negedge clk);
    endtask

    task automatic t_timer_wins();
        timer_req = 1'b1; kbd_req = 1'b1; slot_req = 32'hFFFF_FFFF;
        ack_pass();
        check_out("R3 R7 timer wins", 1, 0, '0, timer_msg, 1);
        @(negedge clk);
        check_out("R6 R11 grant one cycle", 0, 0, '0, '0, 0);
        clear_reqs();
    endtask

    task automatic t_kbd_second();
        kbd_req = 1'b1; slot_req = 32'h8000_0001;
        ack_pass();
        check_out("R4 R7 keyboard beats slots", 0, 1, '0, kbd_msg, 1);
        clear_reqs(); @(negedge clk);
    endtask

    task automatic t_lowest_slot();
        slot_req = (32'h1 << 5) | (32'h1 << 9) | (32'h1 << 31);
        ack_pass();
        check_out("R5 R7 slot5 lowest", 0, 0, 32'h1 << 5, slot_code(5), 1);
        slot_req = 32'h1 << 31;
        ack_pass();
        check_out("R5 R7 slot31 alone", 0, 0, 32'h1 << 31, slot_code(31), 1);
        clear_reqs(); @(negedge clk);
    endtask

    task automatic t_ack_empty();
        ack_pass();
        check_out("R8 empty ack", 0, 0, '0, '0, 0);
    endtask

    task automatic t_later_service();
        slot_req = (32'h1 << 3) | (32'h1 << 12);
        ack_pass();
        check_out("R9 first slot3", 0, 0, 32'h1 << 3, slot_code(3), 1);
        @(negedge clk);
        check_out("R6 held ack gap", 0, 0, '0, '0, 0);
        slot_req[3] = 1'b0;
        ack_pass();
        check_out("R9 loser slot12 later", 0, 0, 32'h1 << 12, slot_code(12), 1);
        clear_reqs(); @(negedge clk);
    endtask

    initial begin
        @(negedge clk);
        t_reset();
        t_int_line();
        t_no_ack();
        t_timer_wins();
        t_kbd_second();
        t_lowest_slot();
        t_ack_empty();
        t_later_service();
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++; errors++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule